// File: doc/BRIEF.md
# Energy-Based Packet Detector with Busy/Idle Hysteresis

This block watches received-signal-strength samples from four RF paths (A, B, C and D) and raises a one-cycle detect pulse when the medium turns busy. Every path keeps a sliding window of its most recent samples. The sum of the newest L samples, with L programmable up to a window maximum, is that path's energy figure. Two thresholds form a hysteresis band, and each threshold has its own qualifying run length. In the idle state a path must stay over the busy threshold for a set number of consecutive samples before the block fires. In the busy state every taking-part path must stay under the idle threshold for its own run length before the block re-arms.

Software sets up the block through a small word-wide register port with three registers: control, thresholds and durations. The control register holds a clear bit and one mask bit per path. A set mask bit removes that path from detection. The sample inputs share one valid strobe. Only strobed cycles count as samples, and the run lengths are counted in accepted samples, not in clock cycles.

Top module: `rssi_energy_detect`

## Requirements
- R1: After the synchronous reset, every register reads back zero, `det_pulse` is low and the detector is idle with empty windows.
- R2: Register map by `reg_addr`. Address 0 is control: bit 31 is clear and bits 3:0 are the mask, with bit 0 for path A, bit 1 for B, bit 2 for C and bit 3 for D. Address 1 is thresholds: bits 31:16 busy and bits 15:0 idle. Address 2 is durations: bits 20:16 average length, bits 15:8 busy run and bits 7:0 idle run. Bits not listed read as zero. Address 3 reads zero and ignores writes. `reg_rdata` shows the register addressed on the previous clock edge.
- R3: A path's energy is the sum of its L most recent accepted samples. L is the average-length field clamped to the range 1..16, so 0 gives 1 and 17..31 give 16. Slots not yet filled since reset or clear count as zero.
- R4: While idle, the block fires when an unmasked path has energy strictly greater than the busy threshold for Nb consecutive accepted samples, where Nb = max(busy run, 1). `det_pulse` is high for the one cycle after the clock edge that accepted the qualifying sample, and the detector becomes busy.
- R5: Each busy episode produces exactly one pulse. No pulse occurs while busy.
- R6: While busy, the detector returns to idle when every unmasked path has energy strictly below the idle threshold for Ni consecutive accepted samples, where Ni = max(idle run, 1). The block can then fire again, and its run counts start from zero.
- R7: A masked path never counts toward firing and never holds off the return to idle. With all four paths masked, the block never fires.
- R8: While the clear bit is 1, the detector is held idle, windows and run counts are zero, samples are ignored and no pulse is produced.
- R9: Cycles without `rssi_valid` change nothing. They neither advance nor break a run, and no pulse follows them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| rssi_valid | input | 1 | Sample strobe for all four paths |
| rssi_a | input | RSSI_W | Path A sample |
| rssi_b | input | RSSI_W | Path B sample |
| rssi_c | input | RSSI_W | Path C sample |
| rssi_d | input | RSSI_W | Path D sample |
| det_pulse | output | 1 | One-cycle busy-detect pulse |

## Verification
The assertions rely on a few input conditions. `rssi_valid` and the samples must be known on every clock edge out of reset. Register writes must be whole-word and land in a single cycle. A pulse is also assumed to come only from a strobed edge in the idle state. The stimulus meets these conditions by driving every input at the falling edge and lowering the strobe during register accesses. Samples are drawn only within the RSSI_W range. The busy and idle thresholds are chosen so the idle threshold never exceeds the busy one, which keeps the hysteresis band meaningful. Masks and clear pulses are still drawn across their full range.

// File: rtl/rssi_det_pkg.sv
package rssi_det_pkg;
  localparam int NPATH = 4;
  localparam int THR_W = 16;
  localparam int DUR_W = 8;
  localparam int AVG_W = 5;

  typedef enum logic {ST_IDLE = 1'b0, ST_BUSY = 1'b1} det_state_t;

  typedef struct packed {
    logic             clear;
    logic [NPATH-1:0] mask;
    logic [THR_W-1:0] thr_busy;
    logic [THR_W-1:0] thr_idle;
    logic [AVG_W-1:0] avg_len;
    logic [DUR_W-1:0] run_busy;
    logic [DUR_W-1:0] run_idle;
  } det_cfg_t;

  function automatic logic [DUR_W-1:0] run_min1(input logic [DUR_W-1:0] v);
    return (v == '0) ? DUR_W'(1) : v;
  endfunction

  function automatic logic [DUR_W-1:0] sat_inc(input logic [DUR_W-1:0] v);
    return (v == '1) ? v : v + 1'b1;
  endfunction
endpackage

// File: rtl/rssi_det_regs.sv
module rssi_det_regs
  import rssi_det_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output det_cfg_t    cfg
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else if (wr_en) begin
      case (addr)
        2'd0: begin
          cfg.clear <= wdata[31];
          cfg.mask  <= wdata[NPATH-1:0];
        end
        2'd1: begin
          cfg.thr_busy <= wdata[31:16];
          cfg.thr_idle <= wdata[15:0];
        end
        2'd2: begin
          cfg.avg_len  <= wdata[16 +: AVG_W];
          cfg.run_busy <= wdata[15:8];
          cfg.run_idle <= wdata[7:0];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= '0;
      case (addr)
        2'd0: begin
          rdata[31]        <= cfg.clear;
          rdata[NPATH-1:0] <= cfg.mask;
        end
        2'd1: rdata <= {cfg.thr_busy, cfg.thr_idle};
        2'd2: begin
          rdata[16 +: AVG_W] <= cfg.avg_len;
          rdata[15:8]        <= cfg.run_busy;
          rdata[7:0]         <= cfg.run_idle;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rssi_det_window.sv
module rssi_det_window #(
  parameter int RSSI_W  = 10,
  parameter int WIN_MAX = 16,
  parameter int LEN_W   = $clog2(WIN_MAX + 1),
  parameter int SUM_W   = RSSI_W + $clog2(WIN_MAX)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              valid,
  input  logic [RSSI_W-1:0] sample,
  input  logic [LEN_W-1:0]  len,
  output logic [SUM_W-1:0]  sum
);
  localparam int HIST = WIN_MAX - 1;

  logic [RSSI_W-1:0] hist [HIST];

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      for (int i = 0; i < HIST; i++) hist[i] <= '0;
    end else if (valid) begin
      hist[0] <= sample;
      for (int i = 1; i < HIST; i++) hist[i] <= hist[i-1];
    end
  end

  // Energy over the newest len taps, the incoming sample being tap 0.
  always_comb begin
    sum = SUM_W'(sample);
    for (int i = 1; i < WIN_MAX; i++) begin
      if (i < int'(len)) sum = sum + SUM_W'(hist[i-1]);
    end
  end
endmodule

// File: rtl/rssi_det_fsm.sv
module rssi_det_fsm
  import rssi_det_pkg::*;
#(
  parameter int SUM_W = 14
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        clear,
  input  logic                        valid,
  input  logic [NPATH-1:0]            mask,
  input  logic [NPATH-1:0][SUM_W-1:0] sums,
  input  logic [THR_W-1:0]            thr_busy,
  input  logic [THR_W-1:0]            thr_idle,
  input  logic [DUR_W-1:0]            run_busy,
  input  logic [DUR_W-1:0]            run_idle,
  output logic                        det_pulse,
  output logic                        busy_q
);
  localparam int CMP_W = (SUM_W > THR_W) ? SUM_W : THR_W;

  det_state_t              st, st_n;
  logic [NPATH-1:0][DUR_W-1:0] bcnt, bcnt_n;
  logic [DUR_W-1:0]        icnt, icnt_n;
  logic [NPATH-1:0]        above, below;
  logic                    fire;
  logic [DUR_W-1:0]        nb, ni;

  assign nb = run_min1(run_busy);
  assign ni = run_min1(run_idle);

  for (genvar p = 0; p < NPATH; p++) begin : g_cmp
    assign above[p] = CMP_W'(sums[p]) > CMP_W'(thr_busy);
    assign below[p] = CMP_W'(sums[p]) < CMP_W'(thr_idle);
  end

  always_comb begin
    st_n   = st;
    bcnt_n = bcnt;
    icnt_n = icnt;
    fire   = 1'b0;
    if (valid) begin
      if (st == ST_IDLE) begin
        for (int p = 0; p < NPATH; p++) begin
          bcnt_n[p] = (mask[p] || !above[p]) ? '0 : sat_inc(bcnt[p]);
          if (!mask[p] && bcnt_n[p] >= nb) fire = 1'b1;
        end
        if (fire) begin
          st_n   = ST_BUSY;
          bcnt_n = '0;
          icnt_n = '0;
        end
      end else begin
        icnt_n = (&(below | mask)) ? sat_inc(icnt) : '0;
        if (icnt_n >= ni) begin
          st_n   = ST_IDLE;
          icnt_n = '0;
          bcnt_n = '0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      st        <= ST_IDLE;
      bcnt      <= '0;
      icnt      <= '0;
      det_pulse <= 1'b0;
    end else begin
      st        <= st_n;
      bcnt      <= bcnt_n;
      icnt      <= icnt_n;
      det_pulse <= fire;
    end
  end

  assign busy_q = (st == ST_BUSY);
endmodule

// File: rtl/rssi_energy_detect.sv
module rssi_energy_detect
  import rssi_det_pkg::*;
#(
  parameter int RSSI_W  = 10,
  parameter int WIN_MAX = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              rssi_valid,
  input  logic [RSSI_W-1:0] rssi_a,
  input  logic [RSSI_W-1:0] rssi_b,
  input  logic [RSSI_W-1:0] rssi_c,
  input  logic [RSSI_W-1:0] rssi_d,
  output logic              det_pulse
);
  localparam int LEN_W = $clog2(WIN_MAX + 1);
  localparam int SUM_W = RSSI_W + $clog2(WIN_MAX);

  det_cfg_t                    cfg;
  logic [LEN_W-1:0]            len;
  logic [NPATH-1:0][RSSI_W-1:0] samp;
  logic [NPATH-1:0][SUM_W-1:0]  sums;
  logic                        clear;
  logic [NPATH-1:0]            mask;
  logic                        busy_q;
  logic                        acc_valid;

  assign clear     = cfg.clear;
  assign mask      = cfg.mask;
  assign acc_valid = rssi_valid && !clear;
  assign samp      = {rssi_d, rssi_c, rssi_b, rssi_a};

  always_comb begin
    if (cfg.avg_len == '0)               len = LEN_W'(1);
    else if (int'(cfg.avg_len) > WIN_MAX) len = LEN_W'(WIN_MAX);
    else                                 len = LEN_W'(cfg.avg_len);
  end

  rssi_det_regs u_regs (
    .clk   (clk),
    .rst   (rst),
    .wr_en (reg_wr_en),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .cfg   (cfg)
  );

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    rssi_det_window #(
      .RSSI_W  (RSSI_W),
      .WIN_MAX (WIN_MAX),
      .LEN_W   (LEN_W),
      .SUM_W   (SUM_W)
    ) u_win (
      .clk    (clk),
      .rst    (rst),
      .clear  (clear),
      .valid  (acc_valid),
      .sample (samp[p]),
      .len    (len),
      .sum    (sums[p])
    );
  end

  rssi_det_fsm #(.SUM_W(SUM_W)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .clear     (clear),
    .valid     (acc_valid),
    .mask      (mask),
    .sums      (sums),
    .thr_busy  (cfg.thr_busy),
    .thr_idle  (cfg.thr_idle),
    .run_busy  (cfg.run_busy),
    .run_idle  (cfg.run_idle),
    .det_pulse (det_pulse),
    .busy_q    (busy_q)
  );
endmodule

// File: rtl/rssi_det_checker.sv
module rssi_det_checker (
  input logic        clk,
  input logic        rst,
  input logic        det_pulse,
  input logic        rssi_valid,
  input logic        clear,
  input logic [3:0]  mask,
  input logic        busy_q,
  input logic [1:0]  reg_addr,
  input logic [31:0] reg_rdata
);
  // R5: a pulse is never followed by another
  p_one_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    det_pulse |=> !det_pulse);

  // R4: firing moves the detector to busy
  p_fire_busy_r4: assert property (@(posedge clk) disable iff (rst)
    det_pulse |-> busy_q);

  // R9: a pulse follows only a strobed edge
  p_needs_valid_r9: assert property (@(posedge clk) disable iff (rst)
    det_pulse |-> $past(rssi_valid));

  // R7: all paths masked means no pulse
  p_all_masked_r7: assert property (@(posedge clk) disable iff (rst)
    (&mask) |=> !det_pulse);

  // R8: clear holds the detector idle and quiet
  p_clear_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    clear |=> (!det_pulse && !busy_q));

  // R2: unlisted control bits and the unused address read zero
  p_ctrl_rsvd_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_addr) == 2'd0) |-> (reg_rdata[30:4] == '0));
  p_addr3_zero_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_addr) == 2'd3) |-> (reg_rdata == '0));
endmodule

bind rssi_energy_detect rssi_det_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .det_pulse  (det_pulse),
  .rssi_valid (rssi_valid),
  .clear      (clear),
  .mask       (mask),
  .busy_q     (busy_q),
  .reg_addr   (reg_addr),
  .reg_rdata  (reg_rdata)
);

// File: tb/tb_rssi_energy_detect.sv
module tb_rssi_energy_detect;
  localparam int RSSI_W = 10;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              reg_wr_en = 1'b0;
  logic [1:0]        reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic              rssi_valid = 1'b0;
  logic [RSSI_W-1:0] rssi_a = '0, rssi_b = '0, rssi_c = '0, rssi_d = '0;
  logic              det_pulse;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  // bench-side model state
  int  hist [4][16];
  bit  m_busy;
  int  bcnt [4];
  int  icnt;
  bit  m_clear;
  int  m_mask, m_tb, m_ti, m_len, m_nb, m_ni;
  int  pulses;

  always #10 clk = ~clk;

  rssi_energy_detect #(.RSSI_W(RSSI_W), .WIN_MAX(16)) dut (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rssi_valid(rssi_valid),
    .rssi_a(rssi_a), .rssi_b(rssi_b), .rssi_c(rssi_c), .rssi_d(rssi_d),
    .det_pulse(det_pulse)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void model_clear();
    for (int p = 0; p < 4; p++) begin
      bcnt[p] = 0;
      for (int k = 0; k < 16; k++) hist[p][k] = 0;
    end
    icnt = 0;
    m_busy = 0;
  endfunction

  function automatic int sat(input int v);
    return (v >= 255) ? 255 : v + 1;
  endfunction

  function automatic bit model_step(input int a, input int b, input int c, input int d);
    int v[4];
    int s;
    bit fire, allb;
    v[0] = a; v[1] = b; v[2] = c; v[3] = d;
    fire = 0;
    allb = 1;
    if (m_clear) return 0;
    for (int p = 0; p < 4; p++) begin
      for (int k = 15; k > 0; k--) hist[p][k] = hist[p][k-1];
      hist[p][0] = v[p];
    end
    for (int p = 0; p < 4; p++) begin
      s = 0;
      for (int k = 0; k < m_len; k++) s += hist[p][k];
      if (!m_busy) begin
        if (m_mask[p] || !(s > m_tb)) bcnt[p] = 0;
        else bcnt[p] = sat(bcnt[p]);
        if (!m_mask[p] && bcnt[p] >= m_nb) fire = 1;
      end else if (!m_mask[p] && !(s < m_ti)) begin
        allb = 0;
      end
    end
    if (!m_busy) begin
      if (fire) begin
        m_busy = 1; icnt = 0;
        for (int p = 0; p < 4; p++) bcnt[p] = 0;
      end
    end else begin
      icnt = allb ? sat(icnt) : 0;
      if (icnt >= m_ni) begin
        m_busy = 0; icnt = 0;
        for (int p = 0; p < 4; p++) bcnt[p] = 0;
      end
    end
    return fire;
  endfunction

  task automatic wr(input int addr, input logic [31:0] data);
    rssi_valid = 1'b0;
    reg_wr_en = 1'b1; reg_addr = 2'(addr); reg_wdata = data;
    @(negedge clk);
    reg_wr_en = 1'b0;
    if (addr == 0) begin
      m_clear = data[31];
      m_mask  = int'(data[3:0]);
      if (m_clear) model_clear();
    end else if (addr == 1) begin
      m_tb = int'(data[31:16]); m_ti = int'(data[15:0]);
    end else if (addr == 2) begin
      m_len = int'(data[20:16]);
      if (m_len == 0) m_len = 1;
      if (m_len > 16) m_len = 16;
      m_nb = (data[15:8] == 0) ? 1 : int'(data[15:8]);
      m_ni = (data[7:0] == 0) ? 1 : int'(data[7:0]);
    end
  endtask

  task automatic rd(input int addr, input logic [31:0] exp, input string req);
    rssi_valid = 1'b0;
    reg_addr = 2'(addr);
    @(negedge clk);
    check(req, reg_rdata, exp);
  endtask

  task automatic sample(input int a, input int b, input int c, input int d, input string req);
    bit e;
    rssi_a = RSSI_W'(a); rssi_b = RSSI_W'(b); rssi_c = RSSI_W'(c); rssi_d = RSSI_W'(d);
    rssi_valid = 1'b1;
    e = model_step(a, b, c, d);
    pulses += int'(e);
    @(negedge clk);
    check(req, det_pulse, e);
  endtask

  task automatic gap(input int n, input string req);
    rssi_valid = 1'b0;
    rssi_a = '1; rssi_b = '1; rssi_c = '1; rssi_d = '1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(req, det_pulse, 0);
    end
  endtask

  initial begin
    int base;
    void'($urandom(32'd4242));
    m_clear = 0; m_mask = 0; m_tb = 0; m_ti = 0; m_len = 1; m_nb = 1; m_ni = 1;
    pulses = 0;
    model_clear();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 pulse", det_pulse, 0);
    rd(0, 32'h0, "R1 ctrl"); rd(1, 32'h0, "R1 thr"); rd(2, 32'h0, "R1 dur");

    // R2 map and unlisted bits
    wr(0, 32'h7FFF_FFF5); rd(0, 32'h0000_0005, "R2 ctrl");
    wr(1, 32'h1234_ABCD); rd(1, 32'h1234_ABCD, "R2 thr");
    wr(2, 32'hFFE3_0201); rd(2, 32'h0003_0201, "R2 dur");
    wr(3, 32'hFFFF_FFFF); rd(3, 32'h0, "R2 addr3");
    rd(0, 32'h0000_0005, "R2 ctrl kept");

    // R4/R5/R6: len 4, busy>300 for 2, idle<100 for 3
    wr(0, 0); wr(1, {16'd300, 16'd100}); wr(2, 32'h0004_0203);
    base = pulses;
    for (int i = 0; i < 4; i++) sample(100, 0, 0, 0, "R4 build");
    check("R4 not yet", pulses - base, 0);
    sample(100, 0, 0, 0, "R4 fire");
    check("R4 fired on fifth", pulses - base, 1);
    for (int i = 0; i < 10; i++) sample(500, 500, 500, 500, "R5 busy");
    check("R5 single", pulses - base, 1);
    for (int i = 0; i < 6; i++) sample(0, 0, 0, 0, "R6 decay");
    for (int i = 0; i < 5; i++) sample(200, 0, 0, 0, "R6 rearm");
    check("R6 second pulse", pulses - base, 2);

    // R3 clamp: field 31 -> 16, value 10, busy >155 for 1
    wr(0, 32'h8000_0000); wr(0, 0);
    wr(1, {16'd155, 16'd0}); wr(2, 32'h001F_0001);
    base = pulses;
    for (int i = 0; i < 15; i++) sample(10, 0, 0, 0, "R3 len16");
    check("R3 len16 quiet", pulses - base, 0);
    sample(10, 0, 0, 0, "R3 len16 fire");
    check("R3 len16 fire", pulses - base, 1);
    // field 0 -> 1
    wr(0, 32'h8000_0000); wr(0, 0); wr(1, {16'd99, 16'd0}); wr(2, 32'h0);
    base = pulses;
    sample(100, 0, 0, 0, "R3 len1");
    check("R3 len1 fire", pulses - base, 1);

    // R7 masking
    wr(0, 32'h8000_0000); wr(0, 32'h1); wr(1, {16'd50, 16'd10}); wr(2, 32'h0001_0101);
    base = pulses;
    for (int i = 0; i < 5; i++) sample(900, 0, 0, 0, "R7 masked A");
    check("R7 masked A", pulses - base, 0);
    sample(0, 0, 0, 900, "R7 path D");
    check("R7 path D", pulses - base, 1);
    sample(0, 0, 0, 0, "R7 masked idle");
    wr(0, 32'hF);
    base = pulses;
    for (int i = 0; i < 5; i++) sample(900, 900, 900, 900, "R7 all masked");
    check("R7 all masked", pulses - base, 0);

    // R8 clear
    wr(0, 0); wr(1, {16'd250, 16'd10}); wr(2, 32'h0004_0101);
    for (int i = 0; i < 2; i++) sample(100, 0, 0, 0, "R8 pre");
    wr(0, 32'h8000_0000);
    base = pulses;
    for (int i = 0; i < 4; i++) sample(900, 900, 900, 900, "R8 held");
    check("R8 no pulse", pulses - base, 0);
    wr(0, 0);
    sample(100, 0, 0, 0, "R8 empty window");
    sample(100, 0, 0, 0, "R8 empty window");
    check("R8 window cleared", pulses - base, 0);

    // R9 gaps do not break a run
    wr(0, 32'h8000_0000); wr(0, 0); wr(1, {16'd50, 16'd10}); wr(2, 32'h0001_0303);
    base = pulses;
    sample(100, 0, 0, 0, "R9 run1"); gap(3, "R9 gap");
    sample(100, 0, 0, 0, "R9 run2"); gap(4, "R9 gap");
    sample(100, 0, 0, 0, "R9 run3");
    check("R9 run across gaps", pulses - base, 1);

    // random phase, all requirements against the model
    for (int ep = 0; ep < 40; ep++) begin
      int tb, ti, hi;
      tb = int'($urandom_range(0, 3000));
      ti = int'($urandom_range(0, tb));
      wr(1, {16'(tb), 16'(ti)});
      wr(2, {11'd0, 5'($urandom_range(0, 31)), 8'($urandom_range(0, 5)), 8'($urandom_range(0, 5))});
      wr(0, {($urandom_range(0, 9) == 0), 27'd0, 4'($urandom_range(0, 15) & $urandom_range(0, 15))});
      for (int i = 0; i < 60; i++) begin
        hi = ((i / 15) % 2 == 0) ? 1023 : 120;
        if ($urandom_range(0, 5) == 0) gap(1, "R9 rand gap");
        sample(int'($urandom_range(0, hi)), int'($urandom_range(0, hi)),
               int'($urandom_range(0, hi)), int'($urandom_range(0, hi)), "R4 R6 rand");
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule